// File: doc/BRIEF.md
# Three-Bit Controlled 32-bit ALU

A purely combinational arithmetic/logic unit for a simple single-issue datapath. Two 32-bit operands enter, a 3-bit function code chooses the operation, and a 32-bit result leaves together with a flag that is high when the result is all zeros. The flag lets a branch unit test two registers for equality by requesting a subtraction and looking at that flag.

The top bit of the function code does two jobs. It selects either the B operand or its complement, and it supplies the adder's carry-in. One adder therefore performs both addition and subtraction. The same code bit also turns AND into AND-NOT and OR into OR-NOT. The two low bits pick one of four results: the bitwise AND, the bitwise OR, the adder output, or the adder's sign bit zero-extended to full width. That last choice is the set-less-than result. Code 011 has no operation assigned and yields zero.

Top module: `alu3_core`

## Requirements
- R1: With f = 3'b000, y equals a AND b.
- R2: With f = 3'b001, y equals a OR b.
- R3: With f = 3'b010, y equals (a + b) modulo 2^32; the carry out is discarded.
- R4: With f = 3'b100, y equals a AND (NOT b); with f = 3'b101, y equals a OR (NOT b).
- R5: With f = 3'b110, y equals (a - b) modulo 2^32, formed as a + ~b + 1.
- R6: With f = 3'b111, y is 32'h0000_0001 when bit 31 of the 32-bit difference a - b is 1, and 32'h0 otherwise. In signed-overflow cases the raw sign bit decides. For example, a = 32'h8000_0000 and b = 1 give 0, and a = 25 and b = 32 give 1.
- R7: With f = 3'b011, the unused code, y is 32'h0 for every operand value.
- R8: zero is 1 exactly when y is 32'h0, for every function code, including the unused one.
- R9: y and zero depend only on the present values of a, b and f; no state is kept between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand, complemented when f[2] is set |
| f | input | 3 | Function code |
| y | output | 32 | Selected result |
| zero | output | 1 | High when y is all zeros |

## Verification
The block has no registers, so any internal fault shows at the ports as soon as the operands settle, in the same cycle as the stimulus. A carry-in that is not tied to the inversion bit shows as a difference or sum that is off by one. A wrong select shows as a logic result where an arithmetic one was expected, or the reverse. The SLT tap is checked on the overflowing operand pairs, where taking the wrong bit gives the opposite answer. The zero flag is compared against the expected result on every sample, including the unused code.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

    localparam int unsigned ALU_W_DEFAULT = 32;
    localparam int unsigned FN_W          = 3;

    // low function bits pick the result source
    typedef enum logic [1:0] {
        PICK_AND = 2'b00,
        PICK_OR  = 2'b01,
        PICK_SUM = 2'b10,
        PICK_SLT = 2'b11
    } pick_e;

    typedef struct packed {
        logic  invert_b;   // complement B and carry in a one
        pick_e pick;       // result source
        logic  blank;      // unassigned code: force result to zero
    } alu_ctrl_t;

endpackage

// File: rtl/alu3_operand_cond.sv
module alu3_operand_cond #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] b_eff_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff_o[i] = b_i[i] ^ invert_i;
    end

    // R4: when inverting, no bit of b may survive unchanged
    always_comb begin
        if (!$isunknown({b_i, invert_i}) && invert_i) begin
            a_r4_invert_all: assert ((b_eff_o & b_i) == '0);
        end
    end

endmodule

// File: rtl/alu3_adder.sv
module alu3_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o
);

    always_comb begin
        sum_o = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i};
    end

endmodule

// File: rtl/alu3_result_mux.sv
module alu3_result_mux
    import alu3_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_ctrl_t        ctrl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_eff_i,
    input  logic [WIDTH-1:0] sum_i,
    output logic [WIDTH-1:0] y_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [WIDTH-1:0] y;
        logic             zero;
    } res_t;

    res_t res_d;

    always_comb begin
        res_d = '0;
        unique case (ctrl_i.pick)
            PICK_AND: res_d.y = a_i & b_eff_i;
            PICK_OR:  res_d.y = a_i | b_eff_i;
            PICK_SUM: res_d.y = sum_i;
            PICK_SLT: res_d.y = {{(WIDTH-1){1'b0}}, sum_i[WIDTH-1]};
            default:  res_d.y = '0;
        endcase
        if (ctrl_i.blank) begin
            res_d.y = '0;
        end
        res_d.zero = ~|res_d.y;
    end

    assign y_o    = res_d.y;
    assign zero_o = res_d.zero;

    // R6: the set-less-than result never exceeds one
    always_comb begin
        if (!$isunknown({ctrl_i, sum_i}) && ctrl_i.pick == PICK_SLT) begin
            a_r6_slt_single_bit: assert ($countones(y_o) <= 1);
        end
    end

endmodule

// File: rtl/alu3_core.sv
module alu3_core
    import alu3_pkg::*;
#(
    parameter int unsigned WIDTH = ALU_W_DEFAULT
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FN_W-1:0]  f,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    localparam logic [FN_W-1:0] FN_UNUSED = 3'b011;

    alu_ctrl_t        ctrl_d;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.invert_b = f[2];
        ctrl_d.pick     = pick_e'(f[1:0]);
        ctrl_d.blank    = (f == FN_UNUSED);
    end

    alu3_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_i      (b),
        .invert_i (ctrl_d.invert_b),
        .b_eff_o  (b_eff)
    );

    alu3_adder #(.WIDTH(WIDTH)) u_add (
        .a_i   (a),
        .b_i   (b_eff),
        .cin_i (ctrl_d.invert_b),
        .sum_o (sum)
    );

    alu3_result_mux #(.WIDTH(WIDTH)) u_mux (
        .ctrl_i  (ctrl_d),
        .a_i     (a),
        .b_eff_i (b_eff),
        .sum_i   (sum),
        .y_o     (y),
        .zero_o  (zero)
    );

    // port-level relations across the submodules
    always_comb begin
        if (!$isunknown({a, b, f, y, zero})) begin
            if (f == 3'b000) begin
                a_r1_and_subset: assert (((y & ~a) == '0) && ((y & ~b) == '0));
            end
            if (f == 3'b001) begin
                a_r2_or_superset: assert (((a & ~y) == '0) && ((b & ~y) == '0));
            end
            if (f == 3'b010) begin
                a_r3_add_inverse: assert ((y - b) == a);
            end
            if (f == 3'b110) begin
                a_r5_sub_inverse: assert ((y + b) == a);
            end
            if (f == 3'b011) begin
                a_r7_unused_blank: assert (y == '0);
            end
            a_r8_zero_flag: assert (zero == (y == '0));
        end
    end

endmodule

// File: tb/alu3_core_tb_top.sv
module alu3_core_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   f = '0;
    logic [W-1:0] y;
    logic         zero;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;  // 250 MHz

    alu3_core dut_i (
        .a    (a),
        .b    (b),
        .f    (f),
        .y    (y),
        .zero (zero)
    );

    function automatic logic [W-1:0] model(input logic [2:0] fn,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] z);
        logic [W-1:0] diff;
        diff = x - z;
        case (fn)
            3'b000:  return x & z;
            3'b001:  return x | z;
            3'b010:  return x + z;
            3'b100:  return x & ~z;
            3'b101:  return x | ~z;
            3'b110:  return diff;
            3'b111:  return {31'b0, diff[W-1]};
            default: return '0;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] fn);
        case (fn)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b100:  return "R4";
            3'b101:  return "R4";
            3'b110:  return "R5";
            3'b111:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run(input logic [2:0] fn, input logic [W-1:0] x, input logic [W-1:0] z);
        logic [W-1:0] exp_y;
        @(negedge clk);
        a = x; b = z; f = fn;
        #1;
        exp_y = model(fn, x, z);
        checks++;
        if (y !== exp_y) begin
            failures++;
            $display("FAIL %s f=%b a=%h b=%h y=%h expected %h", tag(fn), fn, x, z, y, exp_y);
        end
        checks++;
        if (zero !== (exp_y == '0)) begin
            failures++;
            $display("FAIL R8 f=%b a=%h b=%h zero=%b expected %b", fn, x, z, zero, exp_y == '0);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        logic [W-1:0] corners [9];
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                    32'd25, 32'd32, 32'hAAAA_AAAA, 32'h5555_5555};

        // idle state with all inputs low: result zero, flag high
        run(3'b000, '0, '0);

        // R6 worked example and overflow corner
        run(3'b111, 32'd25, 32'd32);
        run(3'b111, 32'h8000_0000, 32'h1);
        run(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);

        // R9: same inputs after other operations give the same outputs
        run(3'b010, 32'd7, 32'd9);
        run(3'b110, 32'hFFFF_0000, 32'h1234);
        run(3'b010, 32'd7, 32'd9);

        // every code over every corner pair (R1..R8)
        for (int fn = 0; fn < 8; fn++) begin
            for (int i = 0; i < 9; i++) begin
                for (int j = 0; j < 9; j++) begin
                    run(3'(fn), corners[i], corners[j]);
                end
            end
        end

        // pseudo-random operands for every code
        for (int k = 0; k < 200; k++) begin
            logic [W-1:0] ra, rb;
            rng = step(rng); ra = rng;
            rng = step(rng); rb = rng;
            for (int fn = 0; fn < 8; fn++) begin
                run(3'(fn), ra, rb);
            end
            run(3'b110, ra, ra);  // equal operands: zero flag for R8
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule